// File: doc/BRIEF.md
# Turbo Ratio Transition Controller

This block picks the operating frequency ratio of a core. It takes a requested ratio, the number of active cores, an indicator of sustained high load and a small set of external limit conditions. From these it forms a target ratio. The target is the request, clipped to a ceiling that depends on the core count, and further clipped to a base ratio while any external limit is active. Moving to a new ratio is never immediate. The block raises a freeze output for a fixed number of reference cycles, and the new ratio appears only on the cycle that freeze drops.

A step down starts as soon as the target falls below the current ratio. A step up starts only after the load indicator has been held high for a full load-detect window. Each step down arms a hysteresis timer, and while that timer runs any step up is refused. The block keeps a 32-bit limit-reasons word. Its low half holds live status bits and its high half holds sticky log bits at the same position plus 16. Software clears log bits by writing ones to them.

Top module: `turbo_ratio_ctl`

## Requirements
- R1: The per-core-count ceiling is 35 for one active core, 33 for two, 32 for three and 31 for four. A count of 0 is treated as 1, and a count above 4 is treated as 4. With high load held, the settled ratio equals min(request, ceiling).
- R2: When the target is below the current ratio, freeze rises on the second clock edge after the new request is driven, with no load condition needed. Freeze then stays high for exactly XFER cycles. The ratio does not change while freeze is high and takes its new value on the cycle freeze falls.
- R3: A step up never starts while the load input is low. Once the load input rises and stays high, with no hysteresis pending, the first cycle with freeze high is cycle LOAD_WIN+1 counted from the rise.
- R4: After a step down starts, no step up starts for HYST cycles: the earliest possible step-up freeze comes HYST+1 cycles after the step-down freeze began. While a step up is refused for this reason, status bit 13 is set.
- R5: Status bit 12 is set while the request exceeds the core-count ceiling, and is clear otherwise.
- R6: External limit input k drives status bit k. While any external limit is active, the target is capped at BASE_RATIO (default 24).
- R7: Each status bit k sets log bit k+16 on the following cycle. The log bit stays set after the status bit clears.
- R8: Pulsing clr_we with clr_mask bit k clears log bit k+16, and leaves log bits not selected by the mask unchanged. If the condition is still active, the log bit is set again one cycle later.
- R9: A request changed while freeze is high is held and evaluated when the freeze ends, and may start a further transition.
- R10: In reset and after it, the ratio equals BASE_RATIO, freeze is low and all 32 reason bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ratio | input | RW | Requested ratio |
| act_cores | input | CW | Number of active cores |
| load_hi | input | 1 | Sustained high-load indicator |
| ext_lim | input | N_EXT | External limit conditions |
| clr_we | input | 1 | Write strobe for clearing log bits |
| clr_mask | input | 16 | Ones select the log bits to clear |
| cur_ratio | output | RW | Currently applied ratio |
| freeze | output | 1 | Core held during a ratio transition |
| reasons | output | 32 | Log bits [31:16], status bits [15:0] |

## Verification
The assertions assume that clr_we pulses come from a software write and only touch the log half, and that inputs change only between clock edges. Under these assumptions a log bit can only grow while no clear is written. They also assume the freeze length bound and the rule that the ratio moves only when freeze falls hold for any input sequence. The stimulus drives every input on the falling edge and uses clear strobes one cycle long. It lets each transition end before it reads a settled ratio. The one exception is the deliberate mid-freeze request change.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int REASON_W  = 32;
   localparam int STAT_W    = 16;
   localparam int LOG_OFS   = 16;
   localparam int BIT_TURBO = 12;
   localparam int BIT_ATTEN = 13;
   localparam int EXT_MAX   = 12;
endpackage

// File: rtl/trc_cap_sel.sv
module trc_cap_sel #(
   parameter int RW = 8,
   parameter int CW = 3,
   parameter int NCORE = 4,
   parameter logic [NCORE*RW-1:0] CAP_TBL = '0,
   parameter int BASE_RATIO = 24
) (
   input  logic [RW-1:0] req,
   input  logic [CW-1:0] cores,
   input  logic          ext_any,
   output logic [RW-1:0] target,
   output logic          over_cap
);
   logic [RW-1:0] caps [NCORE];
   logic [RW-1:0] sel_cap;
   logic [RW-1:0] lim;

   for (genvar g = 0; g < NCORE; g++) begin : g_cap
      assign caps[g] = CAP_TBL[g*RW +: RW];
   end

   always_comb begin
      int idx;
      idx = int'(cores);
      if (idx < 1) idx = 1;
      if (idx > NCORE) idx = NCORE;
      sel_cap = caps[NCORE-1];
      for (int k = 0; k < NCORE; k++) begin
         if (idx == k + 1) sel_cap = caps[k];
      end
   end

   assign over_cap = req > sel_cap;
   assign lim      = (req < sel_cap) ? req : sel_cap;
   assign target   = (ext_any && lim > RW'(BASE_RATIO)) ? RW'(BASE_RATIO) : lim;
endmodule

// File: rtl/trc_xfer.sv
module trc_xfer #(
   parameter int RW = 8,
   parameter int XFER = 20500,
   parameter int INIT_RATIO = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [RW-1:0] new_ratio,
   output logic          freeze,
   output logic [RW-1:0] cur_ratio
);
   localparam int XW = $clog2(XFER + 1);

   logic [XW-1:0] cnt;
   logic [RW-1:0] nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         nxt       <= RW'(INIT_RATIO);
         cur_ratio <= RW'(INIT_RATIO);
      end else if (start) begin
         cnt <= XW'(XFER);
         nxt <= new_ratio;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
         if (cnt == XW'(1)) cur_ratio <= nxt;
      end
   end

   assign freeze = cnt != '0;
endmodule

// File: rtl/trc_reasons.sv
module trc_reasons
   import trc_pkg::*;
#(
   parameter int N_EXT = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_EXT-1:0]    ext_lim,
   input  logic                turbo_clip,
   input  logic                atten,
   input  logic                clr_we,
   input  logic [STAT_W-1:0]   clr_mask,
   output logic [REASON_W-1:0] reasons
);
   logic [STAT_W-1:0] cond;
   logic [STAT_W-1:0] stat;
   logic [STAT_W-1:0] logv;

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (b < N_EXT) begin : g_ext
         assign cond[b] = ext_lim[b];
      end else if (b == BIT_TURBO) begin : g_turbo
         assign cond[b] = turbo_clip;
      end else if (b == BIT_ATTEN) begin : g_att
         assign cond[b] = atten;
      end else begin : g_none
         assign cond[b] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
         logv <= '0;
      end else begin
         stat <= cond;
         if (clr_we) logv <= logv & ~clr_mask;
         else        logv <= logv | stat;
      end
   end

   assign reasons = {logv, stat};
endmodule

// File: rtl/turbo_ratio_ctl.sv
module turbo_ratio_ctl
   import trc_pkg::*;
#(
   parameter int RW = 8,
   parameter int CW = 3,
   parameter int NCORE = 4,
   parameter logic [NCORE*RW-1:0] CAP_TBL = {8'd31, 8'd32, 8'd33, 8'd35},
   parameter int BASE_RATIO = 24,
   parameter int N_EXT = 4,
   parameter int XFER = 20500,
   parameter int LOAD_WIN = 600000,
   parameter int HYST = 4 * LOAD_WIN
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RW-1:0]       req_ratio,
   input  logic [CW-1:0]       act_cores,
   input  logic                load_hi,
   input  logic [N_EXT-1:0]    ext_lim,
   input  logic                clr_we,
   input  logic [15:0]         clr_mask,
   output logic [RW-1:0]       cur_ratio,
   output logic                freeze,
   output logic [31:0]         reasons
);
   localparam int LW = $clog2(LOAD_WIN + 1);
   localparam int HW = $clog2(HYST + 1);

   if (N_EXT < 1 || N_EXT > EXT_MAX) begin : g_bad_ext
      $error("N_EXT out of range");
   end
   if (XFER < 1 || LOAD_WIN < 1 || HYST < 1) begin : g_bad_time
      $error("timing parameters must be positive");
   end
   if (BASE_RATIO >= (1 << RW)) begin : g_bad_base
      $error("BASE_RATIO does not fit RW");
   end

   logic [RW-1:0] req_q;
   logic [RW-1:0] target;
   logic          over_cap;
   logic [LW-1:0] ld_cnt;
   logic [HW-1:0] hyst_cnt;
   logic          up_ok, want_dn, want_up, blocked, start;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= RW'(BASE_RATIO);
      else        req_q <= req_ratio;
   end

   trc_cap_sel #(
      .RW(RW), .CW(CW), .NCORE(NCORE), .CAP_TBL(CAP_TBL), .BASE_RATIO(BASE_RATIO)
   ) u_cap (
      .req(req_q), .cores(act_cores), .ext_any(|ext_lim),
      .target(target), .over_cap(over_cap)
   );

   assign up_ok   = ld_cnt == LW'(LOAD_WIN);
   assign want_dn = !freeze && (target < cur_ratio);
   assign want_up = !freeze && (target > cur_ratio) && up_ok;
   assign blocked = want_up && (hyst_cnt != '0);
   assign start   = want_dn || (want_up && !blocked);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_cnt   <= '0;
         hyst_cnt <= '0;
      end else begin
         if (start || !load_hi)      ld_cnt <= '0;
         else if (!freeze && !up_ok) ld_cnt <= ld_cnt + 1'b1;

         if (want_dn)                hyst_cnt <= HW'(HYST);
         else if (hyst_cnt != '0)    hyst_cnt <= hyst_cnt - 1'b1;
      end
   end

   trc_xfer #(.RW(RW), .XFER(XFER), .INIT_RATIO(BASE_RATIO)) u_xfer (
      .clk(clk), .rst_n(rst_n), .start(start), .new_ratio(target),
      .freeze(freeze), .cur_ratio(cur_ratio)
   );

   trc_reasons #(.N_EXT(N_EXT)) u_rsn (
      .clk(clk), .rst_n(rst_n), .ext_lim(ext_lim), .turbo_clip(over_cap),
      .atten(blocked), .clr_we(clr_we), .clr_mask(clr_mask), .reasons(reasons)
   );
endmodule

// File: rtl/turbo_ratio_ctl_chk.sv
module turbo_ratio_ctl_chk #(
   parameter int RW = 8,
   parameter int XFER = 20500
) (
   input logic          clk,
   input logic          rst_n,
   input logic          freeze,
   input logic [RW-1:0] cur_ratio,
   input logic [31:0]   reasons,
   input logic          clr_we
);
   int fr_len;

   always_ff @(posedge clk) begin
      if (!rst_n)      fr_len <= 0;
      else if (freeze) fr_len <= fr_len + 1;
      else             fr_len <= 0;
   end

   a_r2_freeze_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fr_len <= XFER);

   a_r2_ratio_at_unfreeze: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_ratio != $past(cur_ratio)) |-> $fell(freeze));

   a_r4_atten_not_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      reasons[13] |-> !freeze);

   a_r7_log_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((reasons[31:16] & $past(reasons[15:0])) == $past(reasons[15:0])));

   a_r8_log_only_grows: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((reasons[31:16] & $past(reasons[31:16])) == $past(reasons[31:16])));
endmodule

bind turbo_ratio_ctl turbo_ratio_ctl_chk #(.RW(RW), .XFER(XFER)) u_chk (
   .clk(clk), .rst_n(rst_n), .freeze(freeze), .cur_ratio(cur_ratio),
   .reasons(reasons), .clr_we(clr_we)
);

// File: tb/sim_turbo_ratio_ctl.sv
module sim_turbo_ratio_ctl;
   localparam int CLK_PER  = 10;
   localparam int XFER     = 5;
   localparam int LOAD_WIN = 8;
   localparam int HYST     = 32;
   localparam int BASE     = 24;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  req_ratio;
   logic [2:0]  act_cores;
   logic        load_hi;
   logic [3:0]  ext_lim;
   logic        clr_we;
   logic [15:0] clr_mask;
   logic [7:0]  cur_ratio;
   logic        freeze;
   logic [31:0] reasons;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   turbo_ratio_ctl #(.XFER(XFER), .LOAD_WIN(LOAD_WIN), .HYST(HYST)) u0 (
      .clk(clk), .rst_n(rst_n), .req_ratio(req_ratio), .act_cores(act_cores),
      .load_hi(load_hi), .ext_lim(ext_lim), .clr_we(clr_we), .clr_mask(clr_mask),
      .cur_ratio(cur_ratio), .freeze(freeze), .reasons(reasons)
   );

   function automatic int exp_cap(int c);
      if (c <= 1) return 35;
      if (c == 2) return 33;
      if (c == 3) return 32;
      return 31;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_freeze(output int n);
      n = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         n++;
         if (freeze) break;
      end
   endtask

   task automatic wait_thaw(output int len, output bit moved);
      int r0;
      len = 1;
      moved = 1'b0;
      r0 = int'(cur_ratio);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (!freeze) break;
         len++;
         if (int'(cur_ratio) != r0) moved = 1'b1;
      end
   endtask

   initial begin
      int n, len, el;
      bit mv, att_seen, req_set;
      rst_n = 1'b0; req_ratio = 8'd24; act_cores = 3'd1; load_hi = 1'b0;
      ext_lim = '0; clr_we = 1'b0; clr_mask = '0;
      tick(3);
      chk(cur_ratio == 8'(BASE), "R10 ratio in reset", int'(cur_ratio), BASE);
      chk(!freeze && reasons == '0, "R10 freeze/reasons in reset", int'(reasons), 0);
      rst_n = 1'b1;
      tick(4);
      chk(cur_ratio == 8'(BASE) && !freeze, "R10 after reset", int'(cur_ratio), BASE);
      chk(reasons == '0, "R10 reasons after reset", int'(reasons), 0);

      // R1/R5 sweep over core counts
      load_hi = 1'b1; req_ratio = 8'd40;
      for (int c = 0; c < 6; c++) begin
         act_cores = 3'(c);
         tick(200);
         chk(int'(cur_ratio) == exp_cap(c), "R1 ceiling per core count", int'(cur_ratio), exp_cap(c));
         chk(reasons[12], "R5 clip status set", int'(reasons[12]), 1);
         chk(reasons[28], "R7 clip log set", int'(reasons[28]), 1);
      end
      act_cores = 3'd1; req_ratio = 8'd30;
      tick(200);
      chk(cur_ratio == 8'd30, "R1 request below ceiling", int'(cur_ratio), 30);
      chk(!reasons[12], "R5 clip status clear", int'(reasons[12]), 0);

      // R2 step down
      load_hi = 1'b0;
      req_ratio = 8'd26;
      wait_freeze(n);
      chk(n == 2, "R2 down-step start latency", n, 2);
      wait_thaw(len, mv);
      chk(len == XFER, "R2 freeze length", len, XFER);
      chk(!mv, "R2 ratio held during freeze", int'(mv), 0);
      chk(cur_ratio == 8'd26, "R2 new ratio applied", int'(cur_ratio), 26);

      // R3 step up needs load
      tick(60);
      req_ratio = 8'd35;
      tick(20);
      chk(cur_ratio == 8'd26 && !freeze, "R3 no up-step without load", int'(cur_ratio), 26);
      load_hi = 1'b1;
      wait_freeze(n);
      chk(n == LOAD_WIN + 1, "R3 load window", n, LOAD_WIN + 1);
      wait_thaw(len, mv);
      chk(cur_ratio == 8'd35, "R3 up-step applied", int'(cur_ratio), 35);

      // R4 hysteresis
      req_ratio = 8'd28;
      wait_freeze(n);
      el = 0; att_seen = 1'b0; req_set = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         el++;
         if (reasons[13]) att_seen = 1'b1;
         if (freeze && req_set) break;
         if (!freeze && !req_set) begin
            req_ratio = 8'd35;
            req_set = 1'b1;
         end
      end
      chk(el == HYST + 1, "R4 hysteresis gap", el, HYST + 1);
      chk(att_seen, "R4 attenuation status seen", int'(att_seen), 1);
      chk(reasons[29], "R7 attenuation log", int'(reasons[29]), 1);
      wait_thaw(len, mv);
      chk(cur_ratio == 8'd35, "R4 up-step after hysteresis", int'(cur_ratio), 35);

      // R8 clear all, R6 external limit, R7 sticky
      load_hi = 1'b0;
      tick(2);
      clr_we = 1'b1; clr_mask = 16'hFFFF;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = '0;
      chk(reasons[31:16] == '0, "R8 log cleared", int'(reasons[31:16]), 0);
      ext_lim = 4'b0100;
      tick(3);
      chk(reasons[2], "R6 external status", int'(reasons[2]), 1);
      chk(reasons[18], "R7 external log", int'(reasons[18]), 1);
      tick(20);
      chk(cur_ratio == 8'(BASE), "R6 capped at base", int'(cur_ratio), BASE);
      ext_lim = '0;
      tick(3);
      chk(!reasons[2] && reasons[18], "R7 log sticky after clear of condition", int'(reasons[18]), 1);
      ext_lim = 4'b0010;
      tick(3);
      clr_we = 1'b1; clr_mask = 16'h0002;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = '0;
      chk(!reasons[17], "R8 log bit cleared", int'(reasons[17]), 0);
      chk(reasons[18], "R8 unselected log kept", int'(reasons[18]), 1);
      @(negedge clk);
      chk(reasons[17], "R8 log resets while active", int'(reasons[17]), 1);
      ext_lim = '0;

      // R9 request during freeze
      tick(5);
      req_ratio = 8'd20;
      wait_freeze(n);
      @(negedge clk);
      req_ratio = 8'd18;
      wait_thaw(len, mv);
      chk(cur_ratio == 8'd20, "R9 first transition", int'(cur_ratio), 20);
      wait_freeze(n);
      chk(freeze, "R9 latched request starts freeze", int'(freeze), 1);
      wait_thaw(len, mv);
      chk(cur_ratio == 8'd18, "R9 latched request applied", int'(cur_ratio), 18);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule